// File: doc/BRIEF.md
# Run-Time Reconfigurable Multiply-Add Array

This block is a pipelined array of four signed multipliers that feed two first-stage adder/subtractor units and a second-stage adder. A 2-bit mode input, sampled with each valid operation, decides how the array is used. The array can form one wide complex product (real and imaginary parts). It can split every multiplier into two narrow lanes and form two independent complex products at once. It can form one sum of four wide products. It can form two separate sums of four narrow products each, which suits FIR-style dot products.

Operands arrive on two buses of four fields each. Field k of `x_i` and `y_i` occupies bits [18k+17:18k]. In the narrow modes each field holds two 9-bit lanes: lane 0 in bits [8:0] of the field and lane 1 in bits [17:9]. All values are two's-complement. Inputs and outputs are each registered once, so a result appears two clocks after its valid input. The mode may change on every operation with no stall.

Top module: `mul_add_array`

## Requirements
- R1: Mode 00 (wide complex) uses a = field 0 of x_i, b = field 1 of x_i, c = field 0 of y_i and d = field 1 of y_i. res0_o carries (a*c - b*d) and res1_o carries (a*d + b*c), each as a 37-bit signed value sign-extended to 38 bits.
- R2: Mode 01 (dual narrow complex) applies the R1 formulas separately in lane 0 and lane 1. Each lane result is 19 bits. res0_o = {lane1 real, lane0 real} and res1_o = {lane1 imaginary, lane0 imaginary}, with no carry between the 19-bit fields.
- R3: Mode 10 (wide sum) gives res0_o = the sum over k=0..3 of (field k of x_i) * (field k of y_i), as a 38-bit signed value, and res1_o = 0.
- R4: Mode 11 (dual narrow sum) gives res0_o = the 20-bit sum of the four lane-0 products, sign-extended to 38 bits. res1_o is the same for lane 1. Only 9-bit products enter each sum.
- R5: valid_o is high exactly two clock cycles after valid_i was sampled high, and low two cycles after valid_i was sampled low.
- R6: When no valid result is delivered, res0_o and res1_o keep their previous values, whatever the inputs do.
- R7: A synchronous active-high rst clears valid_o, res0_o and res1_o to zero and discards operations in flight.
- R8: The mode may differ on every consecutive valid cycle. Each operation is computed in the mode sampled with it, with one result per cycle.
- R9: In modes 00 and 01, fields 2 and 3 of x_i and y_i have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operands and mode are valid this cycle |
| mode_i | input | 2 | 00 wide complex, 01 dual narrow complex, 10 wide sum, 11 dual narrow sum |
| x_i | input | 72 | Four signed 18-bit operand fields (a, b in complex modes) |
| y_i | input | 72 | Four signed 18-bit operand fields (c, d in complex modes) |
| valid_o | output | 1 | Result buses hold a new result |
| res0_o | output | 38 | Real part, wide sum, or lane-0 sum |
| res1_o | output | 38 | Imaginary part, zero, or lane-1 sum |

## Verification
On every cycle the embedded properties check several behaviours. They check the two-cycle valid latency and that the results stay frozen when no operation completes. They check that a wide complex result carries a proper 37-bit sign extension, that a narrow sum is confined to its 20-bit field, and that the second bus reads zero in wide sum mode. The arithmetic itself can only be shown by the bench's scenarios. These compare each mode against an independent reference model for extreme and mixed-sign operands. They also cover lane isolation, streams whose mode changes every cycle, the irrelevance of the unused fields, and reset in the middle of a stream.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic [1:0] {
      MODE_CPX_WIDE = 2'b00,
      MODE_CPX_DUAL = 2'b01,
      MODE_SUM_WIDE = 2'b10,
      MODE_SUM_DUAL = 2'b11
   } mac_mode_e;

   // bit 1 selects summing, bit 0 selects the split (narrow) lanes
   function automatic logic mode_is_sum(input mac_mode_e m);
      return m[1];
   endfunction

   function automatic logic mode_is_narrow(input mac_mode_e m);
      return m[0];
   endfunction
endpackage

// File: rtl/mac_operand_route.sv
module mac_operand_route #(
   parameter int W_OP   = 18,
   parameter int N_MULT = 4
) (
   input  logic                         sum_mode_i,
   input  logic [N_MULT-1:0][W_OP-1:0]  x_i,
   input  logic [N_MULT-1:0][W_OP-1:0]  y_i,
   output logic [N_MULT-1:0][W_OP-1:0]  p_o,
   output logic [N_MULT-1:0][W_OP-1:0]  q_o
);
   // complex routing: M0=a*c, M1=b*d, M2=a*d, M3=b*c
   for (genvar k = 0; k < N_MULT; k++) begin : g_route
      localparam int CPX_P = k % 2;
      localparam int CPX_Q = (k % 2) ^ ((k / 2) % 2);
      assign p_o[k] = sum_mode_i ? x_i[k] : x_i[CPX_P];
      assign q_o[k] = sum_mode_i ? y_i[k] : y_i[CPX_Q];
   end
endmodule

// File: rtl/mac_mul_slice.sv
module mac_mul_slice #(
   parameter int W_OP = 18,
   localparam int W_N  = W_OP / 2,
   localparam int PW   = 2 * W_OP,
   localparam int NPW  = 2 * W_N
) (
   input  logic [W_OP-1:0] p_i,
   input  logic [W_OP-1:0] q_i,
   output logic [PW-1:0]   wide_o,
   output logic [NPW-1:0]  lane0_o,
   output logic [NPW-1:0]  lane1_o
);
   logic signed [PW-1:0]  prod_w;
   logic signed [NPW-1:0] prod_l0;
   logic signed [NPW-1:0] prod_l1;

   assign prod_w  = $signed(p_i) * $signed(q_i);
   assign prod_l0 = $signed(p_i[W_N-1:0]) * $signed(q_i[W_N-1:0]);
   assign prod_l1 = $signed(p_i[W_OP-1:W_N]) * $signed(q_i[W_OP-1:W_N]);

   assign wide_o  = prod_w;
   assign lane0_o = prod_l0;
   assign lane1_o = prod_l1;
endmodule

// File: rtl/mac_adder_tree.sv
module mac_adder_tree
   import mac_pkg::*;
#(
   parameter int W_OP = 18,
   localparam int W_N  = W_OP / 2,
   localparam int PW   = 2 * W_OP,
   localparam int NPW  = 2 * W_N,
   localparam int RW   = PW + 2,
   localparam int NCW  = NPW + 1,
   localparam int NSW  = NPW + 2
) (
   input  mac_mode_e                mode_i,
   input  logic [3:0][PW-1:0]       wprod_i,
   input  logic [1:0][3:0][NPW-1:0] nprod_i,
   output logic [RW-1:0]            res0_o,
   output logic [RW-1:0]            res1_o
);
   logic [3:0][RW-1:0] mw;
   logic [RW-1:0]      ws0, ws1, wtot;
   logic [1:0][NSW-1:0] ns0, ns1, ntot;
   logic               sum_m;

   assign sum_m = mode_is_sum(mode_i);

   for (genvar k = 0; k < 4; k++) begin : g_wext
      assign mw[k] = {{(RW-PW){wprod_i[k][PW-1]}}, wprod_i[k]};
   end

   // first stage: unit 0 subtracts in complex modes, unit 1 always adds
   assign ws0  = sum_m ? (mw[0] + mw[1]) : (mw[0] - mw[1]);
   assign ws1  = mw[2] + mw[3];
   assign wtot = ws0 + ws1;

   for (genvar l = 0; l < 2; l++) begin : g_lane
      logic [3:0][NSW-1:0] mn;
      for (genvar k = 0; k < 4; k++) begin : g_next
         assign mn[k] = {{(NSW-NPW){nprod_i[l][k][NPW-1]}}, nprod_i[l][k]};
      end
      assign ns0[l]  = sum_m ? (mn[0] + mn[1]) : (mn[0] - mn[1]);
      assign ns1[l]  = mn[2] + mn[3];
      assign ntot[l] = ns0[l] + ns1[l];
   end

   always_comb begin
      unique case (mode_i)
         MODE_CPX_WIDE: begin
            res0_o = ws0;
            res1_o = ws1;
         end
         MODE_CPX_DUAL: begin
            res0_o = {ns0[1][NCW-1:0], ns0[0][NCW-1:0]};
            res1_o = {ns1[1][NCW-1:0], ns1[0][NCW-1:0]};
         end
         MODE_SUM_WIDE: begin
            res0_o = wtot;
            res1_o = '0;
         end
         default: begin
            res0_o = {{(RW-NSW){ntot[0][NSW-1]}}, ntot[0]};
            res1_o = {{(RW-NSW){ntot[1][NSW-1]}}, ntot[1]};
         end
      endcase
   end
endmodule

// File: rtl/mul_add_array.sv
module mul_add_array
   import mac_pkg::*;
#(
   parameter int W_OP = 18,
   localparam int N_MULT = 4,
   localparam int W_N    = W_OP / 2,
   localparam int PW     = 2 * W_OP,
   localparam int NPW    = 2 * W_N,
   localparam int RW     = PW + 2,
   localparam int NSW    = NPW + 2,
   localparam int XW     = N_MULT * W_OP
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          valid_i,
   input  logic [1:0]    mode_i,
   input  logic [XW-1:0] x_i,
   input  logic [XW-1:0] y_i,
   output logic          valid_o,
   output logic [RW-1:0] res0_o,
   output logic [RW-1:0] res1_o
);
   if (W_OP < 4 || (W_OP % 2) != 0) begin : g_bad_width
      $error("mul_add_array: W_OP must be even and at least 4");
   end
   if (2 * (NPW + 1) != RW) begin : g_bad_pack
      $error("mul_add_array: narrow complex fields do not fill the result bus");
   end

   // input register stage
   logic                        v_q;
   mac_mode_e                   mode_q;
   logic [N_MULT-1:0][W_OP-1:0] x_q, y_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q    <= 1'b0;
         mode_q <= MODE_CPX_WIDE;
         x_q    <= '0;
         y_q    <= '0;
      end else begin
         v_q <= valid_i;
         if (valid_i) begin
            mode_q <= mac_mode_e'(mode_i);
            x_q    <= x_i;
            y_q    <= y_i;
         end
      end
   end

   // routing and multiplier array
   logic [N_MULT-1:0][W_OP-1:0] p_op, q_op;
   logic [3:0][PW-1:0]          wprod;
   logic [1:0][3:0][NPW-1:0]    nprod;

   mac_operand_route #(.W_OP(W_OP), .N_MULT(N_MULT)) u_route (
      .sum_mode_i (mode_is_sum(mode_q)),
      .x_i        (x_q),
      .y_i        (y_q),
      .p_o        (p_op),
      .q_o        (q_op)
   );

   for (genvar k = 0; k < N_MULT; k++) begin : g_mul
      mac_mul_slice #(.W_OP(W_OP)) u_slice (
         .p_i     (p_op[k]),
         .q_i     (q_op[k]),
         .wide_o  (wprod[k]),
         .lane0_o (nprod[0][k]),
         .lane1_o (nprod[1][k])
      );
   end

   logic [RW-1:0] r0_d, r1_d;

   mac_adder_tree #(.W_OP(W_OP)) u_tree (
      .mode_i  (mode_q),
      .wprod_i (wprod),
      .nprod_i (nprod),
      .res0_o  (r0_d),
      .res1_o  (r1_d)
   );

   // output register stage, loaded only by a valid operation
   mac_mode_e mode_q2;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o <= 1'b0;
         res0_o  <= '0;
         res1_o  <= '0;
         mode_q2 <= MODE_CPX_WIDE;
      end else begin
         valid_o <= v_q;
         if (v_q) begin
            res0_o  <= r0_d;
            res1_o  <= r1_d;
            mode_q2 <= mode_q;
         end
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> (valid_o == $past(valid_i, 2))) else $error("valid latency"); // R5

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(valid_i, 2)) |-> ($stable(res0_o) && $stable(res1_o))) else $error("result hold"); // R6

   AST_WIDE_CPX_SEXT: assert property (@(posedge clk) disable iff (rst)
      (valid_o && mode_q2 == MODE_CPX_WIDE) |->
         (res0_o[RW-1] == res0_o[RW-2] && res1_o[RW-1] == res1_o[RW-2])) else $error("wide complex extension"); // R1

   AST_WIDE_SUM_RES1_ZERO: assert property (@(posedge clk) disable iff (rst)
      (valid_o && mode_q2 == MODE_SUM_WIDE) |-> (res1_o == '0)) else $error("wide sum second bus"); // R3

   AST_NARROW_SUM_FIELD: assert property (@(posedge clk) disable iff (rst)
      (valid_o && mode_q2 == MODE_SUM_DUAL) |->
         ((res0_o[RW-1:NSW-1] == '0 || &res0_o[RW-1:NSW-1]) &&
          (res1_o[RW-1:NSW-1] == '0 || &res1_o[RW-1:NSW-1]))) else $error("narrow sum field"); // R4
endmodule

// File: tb/mul_add_array_bench.sv
`timescale 1ns/1ps
module mul_add_array_bench;
   localparam int W  = 18;
   localparam int RW = 38;
   localparam int NV = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          valid_i = 1'b0;
   logic [1:0]    mode_i = 2'b00;
   logic [71:0]   x_i = '0;
   logic [71:0]   y_i = '0;
   logic          valid_o;
   logic [RW-1:0] res0_o, res1_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mul_add_array u_mul_add_array (
      .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
      .x_i(x_i), .y_i(y_i), .valid_o(valid_o), .res0_o(res0_o), .res1_o(res1_o)
   );

   // stimulus table: mode, four x fields, four y fields (18-bit patterns)
   localparam logic [1:0] TV_MODE [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b11};
   localparam int TV_X [NV][4] = '{
      '{3, -5, 12345, -999},               // R9: fields 2,3 are noise
      '{-131072, -131072, 5, 5},
      '{-1436, 70000, 1, 2},
      '{131328, 131328, 0, 0},
      '{-131072, -131072, -131072, -131072},
      '{131071, -77, 1000, -131072},
      '{131328, 131328, 131328, 131328},
      '{-1436, 70000, 130815, -9}};
   localparam int TV_Y [NV][4] = '{
      '{7, 2, -4000, 77},
      '{-131072, 131071, 5, 5},
      '{51234, -255, 3, 4},
      '{131328, 130815, 0, 0},
      '{-131072, -131072, -131072, -131072},
      '{131071, 9, -3, 131071},
      '{131328, 131328, 131328, 131328},
      '{51234, -255, 131328, 600}};

   function automatic logic [71:0] pack4(input int v0, input int v1, input int v2, input int v3);
      return {18'(v3), 18'(v2), 18'(v1), 18'(v0)};
   endfunction

   // independent reference model written from the requirements
   function automatic void model(input logic [1:0] m, input logic [71:0] x, input logic [71:0] y,
                                 output logic [RW-1:0] e0, output logic [RW-1:0] e1);
      longint a [4];
      longint c [4];
      longint al [2][4];
      longint cl [2][4];
      longint r [2];
      longint im [2];
      longint s [2];
      for (int k = 0; k < 4; k++) begin
         a[k] = longint'($signed(x[k*W +: W]));
         c[k] = longint'($signed(y[k*W +: W]));
         for (int l = 0; l < 2; l++) begin
            al[l][k] = longint'($signed(x[k*W + l*9 +: 9]));
            cl[l][k] = longint'($signed(y[k*W + l*9 +: 9]));
         end
      end
      for (int l = 0; l < 2; l++) begin
         r[l]  = al[l][0]*cl[l][0] - al[l][1]*cl[l][1];
         im[l] = al[l][0]*cl[l][1] + al[l][1]*cl[l][0];
         s[l]  = al[l][0]*cl[l][0] + al[l][1]*cl[l][1] + al[l][2]*cl[l][2] + al[l][3]*cl[l][3];
      end
      case (m)
         2'b00: begin e0 = RW'(a[0]*c[0] - a[1]*c[1]); e1 = RW'(a[0]*c[1] + a[1]*c[0]); end
         2'b01: begin e0 = {19'(r[1]), 19'(r[0])}; e1 = {19'(im[1]), 19'(im[0])}; end
         2'b10: begin e0 = RW'(a[0]*c[0] + a[1]*c[1] + a[2]*c[2] + a[3]*c[3]); e1 = '0; end
         default: begin e0 = RW'(s[0]); e1 = RW'(s[1]); end
      endcase
   endfunction

   function automatic string tag_of(input int i);
      case (TV_MODE[i])
         2'b00: return (i == 0) ? "R1 R9" : "R1";
         2'b01: return "R2";
         2'b10: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input int i);
      valid_i = 1'b1;
      mode_i  = TV_MODE[i];
      x_i     = pack4(TV_X[i][0], TV_X[i][1], TV_X[i][2], TV_X[i][3]);
      y_i     = pack4(TV_Y[i][0], TV_Y[i][1], TV_Y[i][2], TV_Y[i][3]);
   endtask

   task automatic expect_vec(input int i, input string req);
      logic [RW-1:0] e0, e1;
      model(TV_MODE[i], pack4(TV_X[i][0], TV_X[i][1], TV_X[i][2], TV_X[i][3]),
            pack4(TV_Y[i][0], TV_Y[i][1], TV_Y[i][2], TV_Y[i][3]), e0, e1);
      chk({req, " valid_o"}, RW'(valid_o), RW'(1));
      chk({req, " res0"}, res0_o, e0);
      chk({req, " res1"}, res1_o, e1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [RW-1:0] h0, h1;
      repeat (3) @(negedge clk);
      // R7: reset state
      chk("R7 reset valid_o", RW'(valid_o), RW'(0));
      chk("R7 reset res0", res0_o, '0);
      chk("R7 reset res1", res1_o, '0);
      rst = 1'b0;

      // table walk, one isolated operation per vector
      for (int i = 0; i < NV; i++) begin
         @(negedge clk); drive(i);
         @(negedge clk); valid_i = 1'b0;
         chk("R5 not yet valid", RW'(valid_o), RW'(0));
         @(negedge clk);
         expect_vec(i, tag_of(i));
      end

      // R6: hold with no valid, inputs toggling
      h0 = res0_o; h1 = res1_o;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         mode_i = 2'(c); x_i = {4{18'h2AAAA}}; y_i = {4{18'h15555}};
      end
      chk("R6 valid_o low", RW'(valid_o), RW'(0));
      chk("R6 res0 held", res0_o, h0);
      chk("R6 res1 held", res1_o, h1);

      // R8 and R5: back-to-back stream, mode changes every cycle
      for (int c = 0; c < NV + 2; c++) begin
         @(negedge clk);
         if (c >= 2) expect_vec((((c - 2) * 5) % NV), "R8");
         if (c < NV) drive((c * 5) % NV);
         else valid_i = 1'b0;
      end
      @(negedge clk);
      chk("R5 valid_o drops", RW'(valid_o), RW'(0));

      // R9: noise only in fields 2,3 changes nothing in complex mode
      @(negedge clk); drive(2);
      x_i[71:36] = '1; y_i[71:36] = {2{18'h20000}};
      @(negedge clk); valid_i = 1'b0;
      @(negedge clk); expect_vec(2, "R9 R2");

      // R7: reset in the middle of a stream
      @(negedge clk); drive(4);
      @(negedge clk); drive(5);
      @(negedge clk); rst = 1'b1; valid_i = 1'b0;
      @(negedge clk); rst = 1'b0;
      chk("R7 mid reset valid_o", RW'(valid_o), RW'(0));
      chk("R7 mid reset res0", res0_o, '0);
      @(negedge clk);
      chk("R7 no stale result", RW'(valid_o), RW'(0));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule